// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital sequencer of a dual-slope integrating analog-to-digital converter. The integrator, the comparator and the reference source stay outside it. A start request launches a conversion. The block then closes the input switch for a fixed run-up window of `T1_CLKS` clocks, so the integrator ramps at a slope set by the unknown voltage.

When the window closes, the block hands the integrator over to the negative reference. It then counts clocks until the external comparator reports that the integrator output is back at or below zero. That count is the run-down time. It equals T1·Vin/Vref, so it is the conversion result. A busy flag covers the whole sequence. A single-cycle done strobe marks the result update, and an overrange flag reports a run-down that never reached zero before the counter hit its top code.

The comparator input is sampled on every rising clock edge. It must already be synchronous to `clk`.

Top module: `dsadc_ctrl`

## Requirements
- R1: During and right after a synchronous active-high reset, `sw_input`, `sw_ref`, `busy`, `done` and `overrange` are 0 and `result` is 0.
- R2: A `conv_start` sampled high while `busy` is 0 sets `busy` and `sw_input` at that same edge. `sw_input` then stays high for exactly `T1_CLKS` clock cycles.
- R3: At the edge where `sw_input` falls at the end of run-up, `sw_ref` rises. There is no gap cycle between them.
- R4: `sw_input` and `sw_ref` are never both 1. Both are 0 whenever `busy` is 0.
- R5: During run-down, the count starts at 0 and increases by one at each edge where `cmp_zero` is sampled 0. At the first edge where `cmp_zero` is sampled 1, `result` takes the count. For an ideal integrator this is ceil(T1·Vin/Vref).
- R6: If the count equals 2^RES_W−1 at an edge where `cmp_zero` is 0, the conversion ends. `result` becomes 2^RES_W−1 and `overrange` becomes 1. A conversion that ends on a comparator trip sets `overrange` to 0.
- R7: If the comparator trips at the same edge where the count is 2^RES_W−1, that edge counts as a normal end. `result` is 2^RES_W−1 and `overrange` is 0.
- R8: `done` is high for exactly one cycle. It rises at the edge where `result` and `overrange` update, and `busy` falls at that same edge.
- R9: A `conv_start` sampled while `busy` is 1 has no effect. This includes the edge at which the conversion completes. The running conversion keeps its timing and result, and `busy` stays 0 after completion.
- R10: `result` and `overrange` keep their last values until the next conversion completes, including all through a new conversion's run-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| conv_start | input | 1 | Start-of-conversion request, sampled on each edge |
| cmp_zero | input | 1 | Comparator: 1 when the integrator output is at or below zero |
| sw_input | output | 1 | Connects the integrator to the analog input |
| sw_ref | output | 1 | Connects the integrator to the negative reference |
| busy | output | 1 | A conversion is in progress |
| done | output | 1 | One-cycle strobe when a new result is stored |
| overrange | output | 1 | Last conversion hit the top code without a zero crossing |
| result | output | RES_W | Last run-down count |

## Verification
Two pairs of events can land on the same edge. The first pair is the comparator trip and the counter reaching its top code. The bench provokes this by choosing input and reference slopes whose ideal run-down is exactly 2^RES_W−1 clocks, and it expects the top code with `overrange` low. The second pair is a new start request and the completion edge. The bench holds `conv_start` high on the very cycle in which it predicts `done` will rise. It then judges that `busy` stays low afterwards and that the finished result is intact.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_RUNUP = 2'd1,
    PH_RUNDN = 2'd2
  } phase_t;

endpackage

// File: rtl/dsadc_counter.sv
module dsadc_counter #(
  parameter int CW     = 12,
  parameter int T1_TOP = 4095,
  parameter int FS_TOP = 4095
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt,
  output logic          at_t1_top,
  output logic          at_fs_top
);

  localparam logic [CW-1:0] T1_LIM = CW'(T1_TOP);
  localparam logic [CW-1:0] FS_LIM = CW'(FS_TOP);

  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

  assign at_t1_top = (cnt == T1_LIM);
  assign at_fs_top = (cnt == FS_LIM);

  // R5: the counter only moves upward, one step at a time
  a_r5_single_step: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/dsadc_phase_fsm.sv
module dsadc_phase_fsm
  import dsadc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic t1_top,
  input  logic fs_top,
  input  logic cmp_zero,
  output logic sw_input,
  output logic sw_ref,
  output logic busy,
  output logic cnt_clr,
  output logic cnt_inc,
  output logic finish,
  output logic finish_ovr
);

  phase_t ph, ph_nxt;

  always_comb begin
    ph_nxt     = ph;
    cnt_clr    = 1'b0;
    cnt_inc    = 1'b0;
    finish     = 1'b0;
    finish_ovr = 1'b0;
    case (ph)
      PH_IDLE: begin
        cnt_clr = 1'b1;
        if (start) ph_nxt = PH_RUNUP;
      end
      PH_RUNUP: begin
        if (t1_top) begin
          cnt_clr = 1'b1;
          ph_nxt  = PH_RUNDN;
        end else begin
          cnt_inc = 1'b1;
        end
      end
      PH_RUNDN: begin
        if (cmp_zero) begin
          finish = 1'b1;
          ph_nxt = PH_IDLE;
        end else if (fs_top) begin
          finish     = 1'b1;
          finish_ovr = 1'b1;
          ph_nxt     = PH_IDLE;
        end else begin
          cnt_inc = 1'b1;
        end
      end
      default: ph_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_IDLE;
      sw_input <= 1'b0;
      sw_ref   <= 1'b0;
      busy     <= 1'b0;
    end else begin
      ph       <= ph_nxt;
      sw_input <= (ph_nxt == PH_RUNUP);
      sw_ref   <= (ph_nxt == PH_RUNDN);
      busy     <= (ph_nxt != PH_IDLE);
    end
  end

  // R4: the two analog switches are mutually exclusive
  a_r4_switch_excl: assert property (@(posedge clk) disable iff (rst)
    !(sw_input && sw_ref));

  // R4: both switches open while idle
  a_r4_idle_open: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!sw_input && !sw_ref));

  // R3: run-up hands straight over to run-down
  a_r3_handover: assert property (@(posedge clk) disable iff (rst)
    $fell(sw_input) |-> sw_ref);

  // R9: a request while busy never restarts run-up
  a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
    sw_ref |=> !sw_input);

endmodule

// File: rtl/dsadc_result.sv
module dsadc_result #(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture,
  input  logic             ovr_in,
  input  logic [RES_W-1:0] cnt_in,
  output logic [RES_W-1:0] result,
  output logic             overrange,
  output logic             done
);

  localparam logic [RES_W-1:0] FS_CODE = {RES_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      overrange <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= capture;
      if (capture) begin
        result    <= cnt_in;
        overrange <= ovr_in;
      end
    end
  end

  // R8: the done strobe is a single cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6: overrange always comes with the full-scale code
  a_r6_ovr_full: assert property (@(posedge clk) disable iff (rst)
    overrange |-> (result == FS_CODE));

  // R10: outputs hold unless a strobe marks an update
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(result) && $stable(overrange)));

endmodule

// File: rtl/dsadc_ctrl.sv
module dsadc_ctrl #(
  parameter int RES_W   = 12,
  parameter int T1_CLKS = 4096
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             conv_start,
  input  logic             cmp_zero,
  output logic             sw_input,
  output logic             sw_ref,
  output logic             busy,
  output logic             done,
  output logic             overrange,
  output logic [RES_W-1:0] result
);

  localparam int T1_W = (T1_CLKS > 1) ? $clog2(T1_CLKS) : 1;
  localparam int CW   = (T1_W > RES_W) ? T1_W : RES_W;
  localparam int FS   = (1 << RES_W) - 1;

  logic          cnt_clr, cnt_inc, t1_top, fs_top;
  logic          finish, finish_ovr;
  logic [CW-1:0] cnt;

  dsadc_counter #(
    .CW     (CW),
    .T1_TOP (T1_CLKS - 1),
    .FS_TOP (FS)
  ) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .clr       (cnt_clr),
    .inc       (cnt_inc),
    .cnt       (cnt),
    .at_t1_top (t1_top),
    .at_fs_top (fs_top)
  );

  dsadc_phase_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .start      (conv_start),
    .t1_top     (t1_top),
    .fs_top     (fs_top),
    .cmp_zero   (cmp_zero),
    .sw_input   (sw_input),
    .sw_ref     (sw_ref),
    .busy       (busy),
    .cnt_clr    (cnt_clr),
    .cnt_inc    (cnt_inc),
    .finish     (finish),
    .finish_ovr (finish_ovr)
  );

  dsadc_result #(
    .RES_W (RES_W)
  ) u_res (
    .clk       (clk),
    .rst       (rst),
    .capture   (finish),
    .ovr_in    (finish_ovr),
    .cnt_in    (cnt[RES_W-1:0]),
    .result    (result),
    .overrange (overrange),
    .done      (done)
  );

  // R8: busy falls on the edge that raises done
  a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  // R2: an idle start request is always accepted
  a_r2_start_taken: assert property (@(posedge clk) disable iff (rst)
    (!busy && conv_start) |=> (busy && sw_input));

endmodule

// File: tb/dsadc_ctrl_tb_top.sv
`timescale 1ns/1ps
module dsadc_ctrl_tb_top;

  localparam int RW   = 6;
  localparam int T1   = 16;
  localparam int MAXC = (1 << RW) - 1;
  localparam int WD   = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic conv_start = 1'b0;
  logic cmp_zero = 1'b0;
  logic sw_input, sw_ref, busy, done, overrange;
  logic [RW-1:0] result;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int integ = 0;
  int vin_r = 0;
  int vref_r = 1;

  always #2 clk = ~clk;

  dsadc_ctrl #(.RES_W(RW), .T1_CLKS(T1)) dut_i (
    .clk(clk), .rst(rst), .conv_start(conv_start), .cmp_zero(cmp_zero),
    .sw_input(sw_input), .sw_ref(sw_ref), .busy(busy), .done(done),
    .overrange(overrange), .result(result)
  );

  // integrator and comparator model, stepped at the falling edge
  always @(negedge clk) begin
    if (sw_ref) begin
      cmp_zero <= (integ <= 0);
      integ    <= integ - vref_r;
    end else if (sw_input) begin
      integ <= integ + vin_r;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD);
      finish_run();
    end
  end

  task automatic run_conv(input int vin, input int vref, input bit poke_runup);
    int raw, eres, k, n_in, n_ref, n_both, old_res;
    bit eovr, prev_in, seen_ref;
    raw  = (T1 * vin + vref - 1) / vref;
    eovr = (raw > MAXC);
    eres = eovr ? MAXC : raw;
    k = eres + 1;
    n_in = 0; n_ref = 0; n_both = 0;
    prev_in = 1'b0; seen_ref = 1'b0;
    @(negedge clk);
    integ = 0; vin_r = vin; vref_r = vref;
    old_res = int'(result);
    conv_start = 1'b1;
    @(negedge clk);
    conv_start = 1'b0;
    chk(busy && sw_input, "R2 start accepted", int'({busy, sw_input}), 3);
    while (!done) begin
      if (sw_input) n_in++;
      if (sw_ref) n_ref++;
      if (sw_input && sw_ref) n_both++;
      if (sw_ref && !seen_ref) begin
        seen_ref = 1'b1;
        chk(prev_in, "R3 handover", int'(prev_in), 1);
        chk(int'(result) == old_res, "R10 result held", int'(result), old_res);
      end
      if (poke_runup && sw_input && n_in == 5) conv_start = 1'b1;   // R9 during run-up
      else if (sw_ref && n_ref == k)           conv_start = 1'b1;   // R9 on completion edge
      else                                     conv_start = 1'b0;
      prev_in = sw_input;
      @(negedge clk);
    end
    conv_start = 1'b0;
    chk(!busy, "R8 busy falls with done", int'(busy), 0);
    chk(int'(result) == eres, eovr ? "R6 full-scale code" : "R5 result", int'(result), eres);
    chk(overrange == eovr, "R6 overrange flag", int'(overrange), int'(eovr));
    chk(n_in == T1, "R2 run-up length", n_in, T1);
    chk(n_both == 0, "R4 switches exclusive", n_both, 0);
    chk(!sw_ref && !sw_input, "R4 switches open at end", int'({sw_input, sw_ref}), 0);
    @(negedge clk);
    chk(!done, "R8 done one cycle", int'(done), 0);
    chk(!busy && !sw_input, "R9 completion-edge start ignored", int'({busy, sw_input}), 0);
  endtask

  initial begin
    int vrefs[5];
    vrefs = '{1, 2, 3, 5, 16};
    repeat (4) @(negedge clk);
    chk(!sw_input && !sw_ref && !busy && !done && !overrange && result == 0,
        "R1 state in reset", int'({sw_input, sw_ref, busy, done, overrange}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!sw_input && !sw_ref && !busy && !done && !overrange && result == 0,
        "R1 state after reset", int'(result), 0);
    // R7: ideal run-down of exactly the top code, then one past it (R6)
    run_conv(63, 16, 1'b0);
    run_conv(64, 16, 1'b1);
    run_conv(0, 1, 1'b1);
    // R5 / R6 sweep over input and reference slopes
    for (int r = 0; r < 5; r++) begin
      for (int v = 0; v <= 70; v++) begin
        run_conv(v, vrefs[r], (v % 3) == 0);
      end
    end
    finish_run();
  end

endmodule